// File: doc/BRIEF.md
# Smart Card Receive Buffer with Block Check

This block takes characters that a smart card receiver has already framed and keeps them in a small first-in first-out store until the host collects them. Each character arrives with a flag that reports a parity error. The block keeps a status byte for the host. That byte shows whether the store is empty or full. It also holds sticky flags for overrun, parity error and a failed block check, and all three flags clear when the host reads the status.

As characters arrive, the block folds each one into a running CRC-16 and into a running XOR. The host arms a last-character flag while the final character of a block is on its way. When that character arrives, the block compares the folded value with a fixed residue. A mode input selects which of the two checks is compared. An error interrupt stays high while any sticky error flag is set.

After an overrun the store is frozen and every further character is dropped until the host reads the status. This means the host never sees a stream with a gap in it that it was not told about.

Top module: `card_rx_buffer`

## Requirements
- R1: A character presented on `rxValid` while the store is neither full nor frozen is stored. Stored characters leave in arrival order. A `dataRd` pulse on a non-empty store puts the oldest character on `dataOut` one clock later. The store holds `DEPTH` characters (default 4).
- R2: `status` bit 0 is 1 exactly when the store is empty, and bit 1 is 1 exactly when it holds `DEPTH` characters. After reset `status` is 8'h01 and `dataOut` is 0.
- R3: A character that arrives while the store is full is dropped, and `status` bit 2 (overrun) is set.
- R4: While overrun is set, every arriving character is dropped, even when the store has free room. This lasts until a status read clears overrun.
- R5: A character flagged with `rxParityErr` is still stored, and `status` bit 3 (parity error) is set.
- R6: A `statusRd` pulse returns the current flags on `status` in that same cycle and clears bits 2, 3 and 4 on the following edge. When a new error occurs in the same cycle as the read, the error wins.
- R7: `irqErr` is 1 exactly when at least one of status bits 2, 3 or 4 is set. An empty store alone leaves `irqErr` at 0.
- R8: With `modeCrc`=1, the check uses a CRC-16 with polynomial 0x1021 and preset 0xFFFF. Each character is folded in least significant bit first: the feedback bit is crc[15] XOR the data bit, the register shifts left, and it is XORed with the polynomial when the feedback bit is 1. When the armed last character has been folded in and the result differs from 0x1D0F, `status` bit 4 (check error) is set.
- R9: With `modeCrc`=0, the XOR of every character of the block, including the final one, must equal 0x00. Otherwise `status` bit 4 is set.
- R10: A `lastArm` pulse sets `status` bit 5. The armed character clears bit 5 and returns both accumulators to their preset values. A `blockStart` pulse also returns both accumulators to their preset values, and the character of that cycle is not folded in.
- R11: A `dataRd` pulse on an empty store leaves `dataOut` at the last value read and does not move the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| rxValid | input | 1 | One-cycle strobe: a received character is present |
| rxByte | input | 8 | Received character |
| rxParityErr | input | 1 | The character on rxByte failed its parity check |
| modeCrc | input | 1 | 1 selects the CRC-16 check, 0 selects the XOR check |
| lastArm | input | 1 | Pulse: the next character closes the block |
| blockStart | input | 1 | Pulse: reset the check accumulators |
| dataRd | input | 1 | Pulse: pop one character from the store |
| dataOut | output | 8 | Last character popped |
| statusRd | input | 1 | Pulse: host reads status; clears sticky flags |
| status | output | 8 | {2'b0, armed, checkErr, parityErr, overrun, full, empty} |
| irqErr | output | 1 | Receive error interrupt |

## Verification
The bench uses the default `DEPTH` of 4, so a few characters are enough to reach full, overrun and the frozen state. That makes it practical to mix those states with random arrivals and reads many times over. The polynomial, preset and residue also stay at their defaults. Passing CRC blocks are built by searching all 65536 tail pairs for the one that lands on 0x1D0F, so good and corrupted blocks are both covered under each check mode.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic accClear;
    logic accFold;
  } rxStrobe_t;

  function automatic logic [15:0] crcFoldByte(input logic [15:0] crcIn,
                                              input logic [7:0] dataIn,
                                              input logic [15:0] poly);
    logic [15:0] crcWork;
    logic fb;
    crcWork = crcIn;
    for (int i = 0; i < 8; i++) begin
      fb = crcWork[15] ^ dataIn[i];
      crcWork = {crcWork[14:0], 1'b0};
      if (fb) crcWork = crcWork ^ poly;
    end
    return crcWork;
  endfunction

endpackage

// File: rtl/card_rx_dp.sv
module card_rx_dp
  import card_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_PRESET = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'h1D0F,
  parameter logic [7:0] LRC_RESIDUE = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              modeCrc,
  output logic [BYTE_W-1:0] dataOut,
  output logic              checkBad
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic [15:0] crcAcc, crcNext;
  logic [BYTE_W-1:0] lrcAcc, lrcNext;

  generate
    if (POW2) begin : g_wrapNatural
      assign wrNext = wrPtr + PTR_W'(1);
      assign rdNext = rdPtr + PTR_W'(1);
    end else begin : g_wrapCompare
      assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrPtr] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      dataOut <= '0;
    end else begin
      if (strb.wrEn) wrPtr <= wrNext;
      if (strb.rdEn) begin
        rdPtr   <= rdNext;
        dataOut <= mem[rdPtr];
      end
    end
  end

  assign crcNext = crcFoldByte(crcAcc, rxByte, CRC_POLY);
  assign lrcNext = lrcAcc ^ rxByte;
  assign checkBad = modeCrc ? (crcNext != CRC_RESIDUE) : (lrcNext != LRC_RESIDUE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcAcc <= CRC_PRESET;
      lrcAcc <= '0;
    end else if (strb.accClear) begin
      crcAcc <= CRC_PRESET;
      lrcAcc <= '0;
    end else if (strb.accFold) begin
      crcAcc <= crcNext;
      lrcAcc <= lrcNext;
    end
  end

  // R11: output only moves on an accepted pop
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(dataOut));

  // R10: clear returns accumulators to preset
  assert_acc_preset_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.accClear |=> (crcAcc == CRC_PRESET) && (lrcAcc == '0));

endmodule

// File: rtl/card_rx_ctl.sv
module card_rx_ctl
  import card_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxValid,
  input  logic      rxParityErr,
  input  logic      lastArm,
  input  logic      blockStart,
  input  logic      dataRd,
  input  logic      statusRd,
  input  logic      checkBad,
  output rxStrobe_t strb,
  output logic [7:0] status,
  output logic      irqErr
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic full, empty, overrun, parityErr, checkErr, lastArmed, evalCheck;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  assign evalCheck     = rxValid && lastArmed && !blockStart;
  assign strb.wrEn     = rxValid && !overrun && !full;
  assign strb.rdEn     = dataRd && !empty;
  assign strb.accClear = blockStart || evalCheck;
  assign strb.accFold  = rxValid && !blockStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      overrun   <= 1'b0;
      parityErr <= 1'b0;
      checkErr  <= 1'b0;
      lastArmed <= 1'b0;
    end else begin
      count <= count + CNT_W'(strb.wrEn) - CNT_W'(strb.rdEn);
      if (rxValid && full)            overrun <= 1'b1;
      else if (statusRd)              overrun <= 1'b0;
      if (rxValid && rxParityErr)     parityErr <= 1'b1;
      else if (statusRd)              parityErr <= 1'b0;
      if (evalCheck && checkBad)      checkErr <= 1'b1;
      else if (statusRd)              checkErr <= 1'b0;
      if (lastArm)                    lastArmed <= 1'b1;
      else if (evalCheck)             lastArmed <= 1'b0;
    end
  end

  assign status = {2'b00, lastArmed, checkErr, parityErr, overrun, full, empty};
  assign irqErr = overrun | parityErr | checkErr;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_overrun_on_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && full) |=> overrun);

  assert_frozen_no_growth_R4: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> count <= $past(count));

  assert_sticky_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !rxValid) |=> !overrun && !parityErr && !checkErr);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqErr) |-> $past(rxValid));

endmodule

// File: rtl/card_rx_buffer.sv
module card_rx_buffer
  import card_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_PRESET = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'h1D0F,
  parameter logic [7:0] LRC_RESIDUE = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       rxParityErr,
  input  logic       modeCrc,
  input  logic       lastArm,
  input  logic       blockStart,
  input  logic       dataRd,
  output logic [7:0] dataOut,
  input  logic       statusRd,
  output logic [7:0] status,
  output logic       irqErr
);
  rxStrobe_t strb;
  logic checkBad;

  card_rx_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxParityErr(rxParityErr),
    .lastArm(lastArm), .blockStart(blockStart), .dataRd(dataRd),
    .statusRd(statusRd), .checkBad(checkBad), .strb(strb),
    .status(status), .irqErr(irqErr)
  );

  card_rx_dp #(
    .DEPTH(DEPTH), .CRC_POLY(CRC_POLY), .CRC_PRESET(CRC_PRESET),
    .CRC_RESIDUE(CRC_RESIDUE), .LRC_RESIDUE(LRC_RESIDUE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte),
    .modeCrc(modeCrc), .dataOut(dataOut), .checkBad(checkBad)
  );

endmodule

// File: tb/card_rx_buffer_bench.sv
module card_rx_buffer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 0, rxParityErr = 0, modeCrc = 1, lastArm = 0, blockStart = 0;
  logic dataRd = 0, statusRd = 0;
  logic [7:0] rxByte = 0;
  logic [7:0] dataOut, status;
  logic irqErr;

  int checks = 0;
  int fails = 0;

  // bench model
  byte unsigned mq[$];
  logic [7:0] lastRead = 0;
  logic mOvr = 0, mPar = 0, mChk = 0, mArmed = 0;
  logic [15:0] mCrc = 16'hFFFF;
  logic [7:0] mLrc = 0;

  always #5 clk = ~clk;

  card_rx_buffer u_card_rx_buffer (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .rxParityErr(rxParityErr), .modeCrc(modeCrc), .lastArm(lastArm),
    .blockStart(blockStart), .dataRd(dataRd), .dataOut(dataOut),
    .statusRd(statusRd), .status(status), .irqErr(irqErr)
  );

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[15] != b[k]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] crcTail(input logic [15:0] s);
    for (int v = 0; v < 65536; v++) begin
      logic [15:0] t = v[15:0];
      if (refCrc(refCrc(s, t[7:0]), t[15:8]) == 16'h1D0F) return t;
    end
    return 16'h0000;
  endfunction

  function automatic logic [7:0] expStatus();
    return {2'b00, mArmed, mChk, mPar, mOvr, (mq.size() == 4), (mq.size() == 0)};
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic p);
    logic [7:0] fin;
    @(negedge clk);
    rxValid = 1; rxByte = b; rxParityErr = p;
    @(posedge clk);
    @(negedge clk);
    rxValid = 0; rxParityErr = 0;
    if (p) mPar = 1;
    if (mq.size() == 4) mOvr = 1;
    else if (!mOvr) mq.push_back(b);
    if (mArmed) begin
      if (modeCrc) mChk = mChk | (refCrc(mCrc, b) != 16'h1D0F);
      else begin fin = mLrc ^ b; mChk = mChk | (fin != 8'h00); end
      mCrc = 16'hFFFF; mLrc = 0; mArmed = 0;
    end else begin
      mCrc = refCrc(mCrc, b); mLrc = mLrc ^ b;
    end
  endtask

  task automatic readData(input string tag);
    @(negedge clk);
    dataRd = 1;
    @(posedge clk);
    @(negedge clk);
    dataRd = 0;
    if (mq.size() != 0) lastRead = mq.pop_front();
    #1 check8(tag, dataOut, lastRead);
  endtask

  task automatic readStatus(input string tag);
    @(negedge clk);
    statusRd = 1;
    #1 check8(tag, status, expStatus());
    check8({tag, " irq R7"}, {7'b0, irqErr}, {7'b0, mOvr | mPar | mChk});
    @(posedge clk);
    @(negedge clk);
    statusRd = 0;
    mOvr = 0; mPar = 0; mChk = 0;
  endtask

  task automatic peekStatus(input string tag);
    @(negedge clk);
    #1 check8(tag, status, expStatus());
  endtask

  task automatic arm();
    @(negedge clk); lastArm = 1;
    @(negedge clk); lastArm = 0;
    mArmed = 1;
  endtask

  task automatic startBlock();
    @(negedge clk); blockStart = 1;
    @(negedge clk); blockStart = 0;
    mCrc = 16'hFFFF; mLrc = 0;
  endtask

  task automatic drain();
    while (mq.size() != 0) readData("R1 drain");
  endtask

  task automatic crcBlock(input bit corrupt, input string tag);
    logic [15:0] s, t;
    modeCrc = 1;
    startBlock();
    s = 16'hFFFF;
    for (int i = 0; i < 3; i++) begin
      logic [7:0] d = 8'($urandom);
      sendByte(d, 0); readData("R1 block");
      s = refCrc(s, d);
    end
    t = crcTail(s);
    sendByte(t[7:0], 0); readData("R1 block");
    arm();
    peekStatus("R10 armed bit");
    sendByte(corrupt ? (t[15:8] ^ 8'h01) : t[15:8], 0); readData("R1 block");
    readStatus(tag);
  endtask

  task automatic lrcBlock(input bit corrupt, input string tag);
    logic [7:0] x;
    modeCrc = 0;
    startBlock();
    x = 0;
    for (int i = 0; i < 3; i++) begin
      logic [7:0] d = 8'($urandom);
      sendByte(d, 0); readData("R1 block");
      x = x ^ d;
    end
    arm();
    sendByte(corrupt ? (x ^ 8'h80) : x, 0); readData("R1 block");
    readStatus(tag);
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R2 reset state
    #1 check8("R2 reset status", status, 8'h01);
    check8("R2 reset dataOut", dataOut, 8'h00);
    check8("R7 reset irq", {7'b0, irqErr}, 8'h00);

    // R1 R2 fill, R3 overrun, R4 frozen
    for (int i = 0; i < 4; i++) sendByte(8'h10 + 8'(i), 0);
    peekStatus("R2 full");
    sendByte(8'hA5, 0);
    peekStatus("R3 overrun set");
    readData("R1 order");
    readData("R1 order");
    sendByte(8'h5A, 0);
    peekStatus("R4 dropped while frozen");
    readStatus("R6 status read overrun");
    peekStatus("R6 cleared");
    sendByte(8'h77, 0);
    drain();
    // R11 empty read
    readData("R11 empty read");
    readData("R11 empty read again");
    peekStatus("R11 still empty");

    // R5 parity errored byte stored
    sendByte(8'h3C, 1);
    peekStatus("R5 parity flag");
    readData("R5 stored byte");
    readStatus("R6 parity read");

    // R8 CRC, R9 LRC
    crcBlock(0, "R8 crc good");
    crcBlock(1, "R8 crc bad");
    lrcBlock(0, "R9 lrc good");
    lrcBlock(1, "R9 lrc bad");

    // R10 block start discards prior junk
    modeCrc = 0;
    sendByte(8'hEE, 0); readData("R10 junk");
    lrcBlock(0, "R10 restart good");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 19);
      if (op < 8) sendByte(8'($urandom), ($urandom_range(0, 7) == 0));
      else if (op < 14) readData("R1 random read");
      else if (op < 17) readStatus("R6 random status");
      else if (op == 17 && !mArmed) arm();
      else if (op == 18) startBlock();
      else modeCrc = 1'($urandom);
    end
    readStatus("R6 final status");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule